// File: doc/BRIEF.md
# Buffer Descriptor Ring Engine

This block walks a transmit ring and a receive ring of buffer descriptors kept in a small internal memory. Each descriptor holds a 16-bit status word, a frame length and a buffer pointer. Software owns the memory through a host port. The engine reads and writes it through its own port. Ownership passes through one bit of the status word. On transmit the bit means "ready to send". On receive it means "empty, free to fill". Each ring ends at a descriptor that carries a wrap bit, so no count register is needed.

On transmit, the engine polls the descriptor at its index. When the ready bit is set, it presents that descriptor's length and pointer on a simple frame-out interface. When the frame is reported done, it clears the ready bit and moves on. On receive, a frame start claims the descriptor at the receive index. The frame end writes the length and the error code and returns the descriptor to software. Both directions have a halt that only software can lift. A graceful stop lets any frame in progress finish and then reports completion through two separate events. Events are sticky, are cleared by writing one, and drive a masked level interrupt.

The transmit machine has four states:
- T_HALT (reset state): leaves to T_POLL on a halt clear, or to T_STOP on a stop request.
- T_POLL: goes to T_SEND if the descriptor is ready, to T_HALT if it is not, or to T_STOP on a stop request.
- T_SEND: returns to T_POLL on frame done.
- T_STOP: returns to T_HALT when the stop request is released.

The receive machine has four states:
- R_IDLE (reset state): goes to R_RECV when a frame starts on an empty descriptor, to R_HALT when a frame starts on a full descriptor, or to R_STOP on a stop request.
- R_RECV: returns to R_IDLE at frame end.
- R_HALT: leaves to R_IDLE on a halt clear, or to R_STOP on a stop request.
- R_STOP: returns to R_IDLE when the stop request is released.

Top module: `bd_ring_engine`

## Requirements
- R1: Transmit presents a descriptor whose status bit 15 (ready) is set: `tx_req` is high, with that descriptor's length and pointer on `tx_len` and `tx_ptr`. When `tx_done` is seen, bit 15 of its status is cleared and every other status bit is kept.
- R2: A completed transmit descriptor whose status bit 12 (interrupt) is set raises event bit 0 (frame sent). A completed descriptor without bit 12 leaves event bit 0 unchanged.
- R3: After a descriptor is processed, the ring index returns to the ring base if that descriptor's status bit 13 (wrap) is set. Otherwise the index advances by one. This holds for both rings.
- R4: Transmit halts (`thalt`=1, no `tx_req`) when the current descriptor is not ready. It stays halted, even after the descriptor becomes ready, until `clr_thalt` is pulsed.
- R5: A receive frame claims the descriptor at the receive index when its bit 15 (empty) is set. At `rx_end`, the status becomes the old value with bit 15 cleared and bits 2:0 replaced by `rx_err`, and the length becomes `rx_len`.
- R6: A frame start on a descriptor whose bit 15 is clear raises event bit 1 (busy) and sets `rhalt`. That descriptor is left untouched. Later frames are ignored until `clr_rhalt` is pulsed.
- R7: While `stop_tx` is held, a transmit frame in progress completes first and then event bit 2 is raised, with no further frame started. While `stop_rx` is held, event bit 3 is raised once receive is idle or halted, and frames arriving while stopped write nothing.
- R8: Event bits are sticky. Writing one to a bit of `evt_clr` clears that bit, and a set in the same cycle wins. `irq` is high exactly when some event bit and its `evt_mask` bit are both set.
- R9: A pulse on `eng_start` resets both ring indices to `tx_base` and `rx_base`.
- R10: When the host port and the engine write the same descriptor status word in the same cycle, the engine's value is stored.
- R11: After reset `thalt`=1, `rhalt`=0, `tx_req`=0, `evt`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_start | input | 1 | Pulse: reload both ring indices from the bases |
| tx_base | input | AW | Index of the first transmit descriptor |
| rx_base | input | AW | Index of the first receive descriptor |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host descriptor index |
| host_sel | input | 2 | Field select: 0 status, 1 length, 2 pointer |
| host_wdata | input | PTR_W | Host write data |
| host_rdata | output | PTR_W | Selected field, zero extended |
| clr_thalt | input | 1 | Pulse: lift the transmit halt |
| clr_rhalt | input | 1 | Pulse: lift the receive halt |
| stop_tx | input | 1 | Graceful stop request, transmit |
| stop_rx | input | 1 | Graceful stop request, receive |
| evt_clr | input | 4 | Write-one-to-clear for event bits |
| evt_mask | input | 4 | Interrupt enable per event bit |
| evt | output | 4 | Events: 0 sent, 1 busy, 2 tx stopped, 3 rx stopped |
| irq | output | 1 | Level interrupt |
| thalt | output | 1 | Transmit halted |
| rhalt | output | 1 | Receive halted |
| tx_req | output | 1 | A frame is presented for sending |
| tx_len | output | LEN_W | Length of the presented frame |
| tx_ptr | output | PTR_W | Buffer pointer of the presented frame |
| tx_done | input | 1 | Pulse: presented frame has been sent |
| rx_start | input | 1 | Pulse: a receive frame begins |
| rx_end | input | 1 | Pulse: the receive frame ends |
| rx_len | input | LEN_W | Received length, FCS included |
| rx_err | input | 3 | Receive error code |

## Verification
Two collisions are provoked. In the first, a host write lands on the status word of the receive descriptor that the engine closes in the same cycle. The host drives `host_we` on the very edge that samples `rx_end`. Read-back must then show the engine's value (empty cleared, error code 2) rather than the host's 0x7FFF. In the second, graceful stop meets a frame in progress. `stop_tx` is raised while `tx_req` is high, and the stop event must stay clear until `tx_done` arrives. A second ready descriptor must then never be presented.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
    localparam int ST_W     = 16;
    localparam int OWN_BIT  = 15;
    localparam int WRAP_BIT = 13;
    localparam int INT_BIT  = 12;
    localparam int ERR_W    = 3;

    localparam int EV_N    = 4;
    localparam int EV_TXF  = 0;
    localparam int EV_BSY  = 1;
    localparam int EV_GTSC = 2;
    localparam int EV_GRSC = 3;

    localparam logic [1:0] SEL_ST  = 2'd0;
    localparam logic [1:0] SEL_LEN = 2'd1;
    localparam logic [1:0] SEL_PTR = 2'd2;

    typedef enum logic [1:0] {T_HALT, T_POLL, T_SEND, T_STOP} tx_state_e;
    typedef enum logic [1:0] {R_IDLE, R_RECV, R_HALT, R_STOP} rx_state_e;
endpackage

// File: rtl/bd_desc_mem.sv
module bd_desc_mem
    import bd_ring_pkg::*;
#(
    parameter int N_DESC = 8,
    parameter int LEN_W  = 16,
    parameter int PTR_W  = 32,
    localparam int AW    = $clog2(N_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [1:0]       host_sel,
    input  logic [PTR_W-1:0] host_wdata,
    output logic [PTR_W-1:0] host_rdata,
    input  logic [AW-1:0]    tx_addr,
    output logic [ST_W-1:0]  tx_st,
    output logic [LEN_W-1:0] tx_len,
    output logic [PTR_W-1:0] tx_ptr,
    input  logic             tx_we,
    input  logic [ST_W-1:0]  tx_wst,
    input  logic [AW-1:0]    rx_addr,
    output logic [ST_W-1:0]  rx_st,
    input  logic             rx_we,
    input  logic [ST_W-1:0]  rx_wst,
    input  logic [LEN_W-1:0] rx_wlen
);
    logic [ST_W-1:0]  st_q  [N_DESC];
    logic [LEN_W-1:0] len_q [N_DESC];
    logic [PTR_W-1:0] ptr_q [N_DESC];

    // Engine ports take priority over the host on every field they write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_DESC; i++) begin
                st_q[i]  <= '0;
                len_q[i] <= '0;
                ptr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_DESC; i++) begin
                if (rx_we && rx_addr == AW'(i))
                    st_q[i] <= rx_wst;
                else if (tx_we && tx_addr == AW'(i))
                    st_q[i] <= tx_wst;
                else if (host_we && host_sel == SEL_ST && host_addr == AW'(i))
                    st_q[i] <= host_wdata[ST_W-1:0];

                if (rx_we && rx_addr == AW'(i))
                    len_q[i] <= rx_wlen;
                else if (host_we && host_sel == SEL_LEN && host_addr == AW'(i))
                    len_q[i] <= host_wdata[LEN_W-1:0];

                if (host_we && host_sel == SEL_PTR && host_addr == AW'(i))
                    ptr_q[i] <= host_wdata;
            end
        end
    end

    always_comb begin
        unique case (host_sel)
            SEL_ST:  host_rdata = PTR_W'(st_q[host_addr]);
            SEL_LEN: host_rdata = PTR_W'(len_q[host_addr]);
            SEL_PTR: host_rdata = ptr_q[host_addr];
            default: host_rdata = '0;
        endcase
    end

    assign tx_st  = st_q[tx_addr];
    assign tx_len = len_q[tx_addr];
    assign tx_ptr = ptr_q[tx_addr];
    assign rx_st  = st_q[rx_addr];

    AST_ENGINE_WINS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && !rx_we && host_we && host_sel == SEL_ST && host_addr == tx_addr)
        |=> st_q[$past(tx_addr)] == $past(tx_wst)); // R10
    AST_ENGINE_WINS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_we && host_we && host_sel == SEL_ST && host_addr == rx_addr)
        |=> st_q[$past(rx_addr)] == $past(rx_wst)); // R10
endmodule

// File: rtl/bd_tx_ring.sv
module bd_tx_ring
    import bd_ring_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   base,
    input  logic            clr_halt,
    input  logic            stop,
    input  logic            done,
    input  logic [ST_W-1:0] st_i,
    output logic [AW-1:0]   idx,
    output logic            req,
    output logic            we,
    output logic [ST_W-1:0] wst,
    output logic            txf_set,
    output logic            gtsc_set,
    output logic            halted
);
    tx_state_e     state_q, state_d;
    logic [AW-1:0] idx_q, idx_nx;

    assign idx_nx = st_i[WRAP_BIT] ? base : idx_q + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_HALT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)
                idx_q <= base;
            else if (state_q == T_SEND && done)
                idx_q <= idx_nx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_HALT: if (stop) state_d = T_STOP;
                    else if (clr_halt) state_d = T_POLL;
            T_POLL: if (stop) state_d = T_STOP;
                    else if (st_i[OWN_BIT]) state_d = T_SEND;
                    else state_d = T_HALT;
            T_SEND: if (done) state_d = T_POLL;
            T_STOP: if (!stop) state_d = T_HALT;
            default: state_d = T_HALT;
        endcase
    end

    always_comb begin
        req      = (state_q == T_SEND);
        we       = (state_q == T_SEND) && done;
        wst      = st_i & ~(ST_W'(1) << OWN_BIT);
        txf_set  = we && st_i[INT_BIT];
        gtsc_set = (state_q != T_STOP) && (state_d == T_STOP);
        halted   = (state_q == T_HALT);
    end

    assign idx = idx_q;

    AST_TX_SEND_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(st_i[OWN_BIT])); // R1
    AST_THALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !clr_halt && !stop) |=> halted); // R4
    AST_GTSC_NOT_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !gtsc_set); // R7
endmodule

// File: rtl/bd_rx_ring.sv
module bd_rx_ring
    import bd_ring_pkg::*;
#(
    parameter int AW    = 3,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base,
    input  logic             clr_halt,
    input  logic             stop,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] len_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [ST_W-1:0]  st_i,
    output logic [AW-1:0]    idx,
    output logic             we,
    output logic [ST_W-1:0]  wst,
    output logic [LEN_W-1:0] wlen,
    output logic             bsy_set,
    output logic             grsc_set,
    output logic             halted
);
    localparam logic [ST_W-1:0] CLR_MASK = ~((ST_W'(1) << OWN_BIT) | ST_W'((1 << ERR_W) - 1));

    rx_state_e     state_q, state_d;
    logic [AW-1:0] idx_q, idx_nx;

    assign idx_nx = st_i[WRAP_BIT] ? base : idx_q + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)
                idx_q <= base;
            else if (state_q == R_RECV && frame_end)
                idx_q <= idx_nx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (stop) state_d = R_STOP;
                    else if (frame_start) state_d = st_i[OWN_BIT] ? R_RECV : R_HALT;
            R_RECV: if (frame_end) state_d = R_IDLE;
            R_HALT: if (stop) state_d = R_STOP;
                    else if (clr_halt) state_d = R_IDLE;
            R_STOP: if (!stop) state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_comb begin
        we       = (state_q == R_RECV) && frame_end;
        wst      = (st_i & CLR_MASK) | ST_W'(err_i);
        wlen     = len_i;
        bsy_set  = (state_q == R_IDLE) && (state_d == R_HALT);
        grsc_set = (state_q != R_STOP) && (state_d == R_STOP);
        halted   = (state_q == R_HALT);
    end

    assign idx = idx_q;

    AST_RX_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !we); // R6
    AST_RHALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !clr_halt && !stop) |=> halted); // R6
endmodule

// File: rtl/bd_evt_bank.sv
module bd_evt_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] evt_o,
    output logic         irq_o
);
    logic [N-1:0] evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_i) | set_i;
    end

    assign evt_o = evt_q;
    assign irq_o = |(evt_q & mask_i);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i))); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R8
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
    import bd_ring_pkg::*;
#(
    parameter int N_DESC = 8,
    parameter int LEN_W  = 16,
    parameter int PTR_W  = 32,
    localparam int AW    = $clog2(N_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_start,
    input  logic [AW-1:0]    tx_base,
    input  logic [AW-1:0]    rx_base,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [1:0]       host_sel,
    input  logic [PTR_W-1:0] host_wdata,
    output logic [PTR_W-1:0] host_rdata,
    input  logic             clr_thalt,
    input  logic             clr_rhalt,
    input  logic             stop_tx,
    input  logic             stop_rx,
    input  logic [3:0]       evt_clr,
    input  logic [3:0]       evt_mask,
    output logic [3:0]       evt,
    output logic             irq,
    output logic             thalt,
    output logic             rhalt,
    output logic             tx_req,
    output logic [LEN_W-1:0] tx_len,
    output logic [PTR_W-1:0] tx_ptr,
    input  logic             tx_done,
    input  logic             rx_start,
    input  logic             rx_end,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [2:0]       rx_err
);
    logic [AW-1:0]    tx_idx, rx_idx;
    logic [ST_W-1:0]  tx_st, rx_st, tx_wst, rx_wst;
    logic [LEN_W-1:0] rx_wlen;
    logic             tx_we, rx_we;
    logic             txf_set, gtsc_set, bsy_set, grsc_set;
    logic [EV_N-1:0]  ev_set;

    bd_desc_mem #(.N_DESC(N_DESC), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_addr(tx_idx), .tx_st(tx_st), .tx_len(tx_len), .tx_ptr(tx_ptr),
        .tx_we(tx_we), .tx_wst(tx_wst),
        .rx_addr(rx_idx), .rx_st(rx_st), .rx_we(rx_we), .rx_wst(rx_wst),
        .rx_wlen(rx_wlen)
    );

    bd_tx_ring #(.AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .base(tx_base),
        .clr_halt(clr_thalt), .stop(stop_tx), .done(tx_done), .st_i(tx_st),
        .idx(tx_idx), .req(tx_req), .we(tx_we), .wst(tx_wst),
        .txf_set(txf_set), .gtsc_set(gtsc_set), .halted(thalt)
    );

    bd_rx_ring #(.AW(AW), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .base(rx_base),
        .clr_halt(clr_rhalt), .stop(stop_rx), .frame_start(rx_start),
        .frame_end(rx_end), .len_i(rx_len), .err_i(rx_err), .st_i(rx_st),
        .idx(rx_idx), .we(rx_we), .wst(rx_wst), .wlen(rx_wlen),
        .bsy_set(bsy_set), .grsc_set(grsc_set), .halted(rhalt)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[EV_TXF]  = txf_set;
        ev_set[EV_BSY]  = bsy_set;
        ev_set[EV_GTSC] = gtsc_set;
        ev_set[EV_GRSC] = grsc_set;
    end

    bd_evt_bank #(.N(EV_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(evt_clr),
        .mask_i(evt_mask), .evt_o(evt), .irq_o(irq)
    );

    AST_BUSY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[EV_BSY]) |-> rhalt); // R6
endmodule

// File: tb/bd_ring_engine_tb_top.sv
module bd_ring_engine_tb_top;
    localparam int AW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_start = 0, host_we = 0, clr_thalt = 0, clr_rhalt = 0;
    logic        stop_tx = 0, stop_rx = 0, tx_done = 0, rx_start = 0, rx_end = 0;
    logic [AW-1:0] tx_base = 3'd0, rx_base = 3'd4, host_addr = '0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [3:0]  evt_clr = '0, evt_mask = '0, evt;
    logic        irq, thalt, rhalt, tx_req;
    logic [15:0] tx_len, rx_len = '0;
    logic [31:0] tx_ptr;
    logic [2:0]  rx_err = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bd_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .tx_base(tx_base),
        .rx_base(rx_base), .host_we(host_we), .host_addr(host_addr),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .clr_thalt(clr_thalt), .clr_rhalt(clr_rhalt), .stop_tx(stop_tx),
        .stop_rx(stop_rx), .evt_clr(evt_clr), .evt_mask(evt_mask), .evt(evt),
        .irq(irq), .thalt(thalt), .rhalt(rhalt), .tx_req(tx_req),
        .tx_len(tx_len), .tx_ptr(tx_ptr), .tx_done(tx_done),
        .rx_start(rx_start), .rx_end(rx_end), .rx_len(rx_len), .rx_err(rx_err)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hwr(input int a, input int sel, input int d);
        host_we = 1; host_addr = AW'(a); host_sel = 2'(sel); host_wdata = 32'(d);
        cyc(1);
        host_we = 0;
    endtask

    task automatic hrd(input int a, input int sel, output int d);
        host_addr = AW'(a); host_sel = 2'(sel);
        #1 d = int'(host_rdata);
    endtask

    task automatic pulse_clr_thalt(); clr_thalt = 1; cyc(1); clr_thalt = 0; endtask
    task automatic pulse_start();     eng_start = 1; cyc(1); eng_start = 0; endtask

    task automatic wait_req(input string tag);
        int n = 0;
        while (!tx_req && n < 20) begin cyc(1); n++; end
        check(int'(tx_req), 1, tag);
    endtask

    task automatic send_done(); tx_done = 1; cyc(1); tx_done = 0; cyc(1); endtask

    task automatic rx_frame(input int len, input int err);
        rx_start = 1; cyc(1); rx_start = 0; cyc(1);
        rx_end = 1; rx_len = 16'(len); rx_err = 3'(err); cyc(1); rx_end = 0; cyc(1);
    endtask

    initial begin
        int d;
        cyc(2);
        // R11 reset state
        check(int'(thalt), 1, "R11 thalt");
        check(int'(rhalt), 0, "R11 rhalt");
        check(int'(tx_req), 0, "R11 tx_req");
        check(int'(evt), 0, "R11 evt");
        check(int'(irq), 0, "R11 irq");
        rst_n = 1;
        cyc(1);

        // tx ring 0..2, rx ring 4..6
        hwr(0, 0, 'h9C00); hwr(0, 1, 60); hwr(0, 2, 'h1000);
        hwr(1, 0, 'h8C00); hwr(1, 1, 64); hwr(1, 2, 'h2000);
        hwr(2, 0, 'h2000);
        hwr(4, 0, 'h8000); hwr(5, 0, 'h8000); hwr(6, 0, 'hA000);
        pulse_start();
        pulse_clr_thalt();

        wait_req("R1 first req");
        check(int'(tx_len), 60, "R1 tx_len");
        check(int'(tx_ptr), 'h1000, "R1 tx_ptr");
        send_done();
        hrd(0, 0, d); check(d, 'h1C00, "R1 ready cleared");
        check(int'(evt[0]), 1, "R2 sent event");
        evt_clr = 4'b0001; cyc(1); evt_clr = '0; cyc(1);
        check(int'(evt[0]), 0, "R8 w1c");

        wait_req("R3 advance req");
        check(int'(tx_len), 64, "R3 next descriptor");
        send_done();
        check(int'(evt[0]), 0, "R2 no interrupt bit");
        hrd(1, 0, d); check(d, 'h0C00, "R1 status kept");
        cyc(3);
        check(int'(thalt), 1, "R4 halted on not ready");
        hwr(2, 0, 'hBC00); hwr(2, 1, 80);
        hwr(0, 0, 'h9C00); hwr(0, 1, 100);
        cyc(5);
        check(int'(tx_req), 0, "R4 stays halted");
        pulse_clr_thalt();
        wait_req("R4 resume req");
        check(int'(tx_len), 80, "R4 resumed descriptor");
        send_done();
        wait_req("R3 wrap req");
        check(int'(tx_len), 100, "R3 wrap to base");
        send_done();

        // R8 mask and irq
        cyc(2);
        check(int'(irq), 0, "R8 masked");
        evt_mask = 4'b0001; #1;
        check(int'(irq), 1, "R8 unmasked");
        cyc(1);
        evt_clr = 4'b0001; cyc(1); evt_clr = '0;
        check(int'(irq), 0, "R8 cleared irq");
        evt_mask = '0;

        // receive ring
        rx_frame(68, 0);
        hrd(4, 0, d); check(d, 'h0000, "R5 status");
        hrd(4, 1, d); check(d, 68, "R5 length");
        rx_frame(72, 5);
        hrd(5, 0, d); check(d, 'h0005, "R5 error code");
        hrd(5, 1, d); check(d, 72, "R5 length2");
        rx_frame(90, 0);
        hrd(6, 0, d); check(d, 'h2000, "R3 rx wrap kept");
        rx_frame(50, 1);
        check(int'(rhalt), 1, "R6 rhalt");
        check(int'(evt[1]), 1, "R6 busy event");
        hrd(4, 1, d); check(d, 68, "R6 untouched");
        hwr(4, 0, 'h8000);
        rx_frame(40, 0);
        hrd(4, 0, d); check(d, 'h8000, "R6 ignored while halted");
        clr_rhalt = 1; cyc(1); clr_rhalt = 0; cyc(1);
        check(int'(rhalt), 0, "R6 halt cleared");

        // R10 same-cycle write collision on descriptor 4
        rx_start = 1; cyc(1); rx_start = 0; cyc(1);
        rx_end = 1; rx_len = 44; rx_err = 2;
        host_we = 1; host_addr = 3'd4; host_sel = 2'd0; host_wdata = 'h7FFF;
        cyc(1);
        rx_end = 0; host_we = 0; cyc(1);
        hrd(4, 0, d); check(d, 'h0002, "R10 engine wins");
        hrd(4, 1, d); check(d, 44, "R5 length on collision");

        // R9 start resets tx index (currently at 1)
        hwr(0, 0, 'h9C00); hwr(0, 1, 33);
        hwr(1, 0, 'h8C00); hwr(1, 1, 34);
        pulse_start();
        pulse_clr_thalt();
        wait_req("R9 req after start");
        check(int'(tx_len), 33, "R9 index at base");

        // R7 graceful stop with frame in flight
        hwr(4, 0, 'h8000);
        stop_tx = 1; stop_rx = 1;
        cyc(3);
        check(int'(evt[2]), 0, "R7 tx stop waits");
        check(int'(evt[3]), 1, "R7 rx stop done");
        send_done();
        cyc(1);
        check(int'(evt[2]), 1, "R7 tx stop done");
        check(int'(tx_req), 0, "R7 no new frame");
        rx_frame(77, 0);
        hrd(4, 1, d); check(d, 44, "R7 rx ignored while stopped");
        stop_tx = 0; stop_rx = 0;
        cyc(2);
        check(int'(thalt), 1, "R7 halted after stop");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule